// File: doc/BRIEF.md
# Five-channel PWM timer

This block generates five pulse-width-modulated outputs from a common tick enable. Each channel owns a down-counter with an active count and compare pair, plus a software-visible count buffer and compare buffer. Software writes the buffers and then raises the channel's manual-update flag to copy them into the active pair. Once the flag is cleared, the channel counts down by one on every tick while its start flag is set. Its output is asserted while the counter is at or below the compare value.

A single shared control word holds the four flags of every channel: start, manual update, invert and auto-reload. Each channel has one nibble of that word. The layout is irregular, and software depends on it. A one-nibble hole follows channel 0. The last channel has no invert flag, and its auto-reload flag sits one position lower than on the other channels. With auto-reload set, a channel takes its buffers again at every expiry. Without it, the channel runs a single period and then goes quiet.

Each channel is a four-state machine, with states `CH_STOP`, `CH_LOAD`, `CH_RUN` and `CH_DONE`. The transitions are as follows:
- Any state moves to `CH_LOAD` while manual update is set. This is the transition *arm*.
- `CH_LOAD` moves to `CH_RUN` when manual update clears with start set (*launch*). With start clear it moves to `CH_STOP` (*park*).
- `CH_STOP` moves to `CH_RUN` when start is set (*resume*).
- `CH_RUN` moves to `CH_STOP` when start clears (*halt*).
- `CH_RUN` moves to `CH_DONE` on an expiry tick with auto-reload clear (*expire*).
- `CH_DONE` moves to `CH_STOP` when start clears (*release*).
- `CH_RUN` stays in `CH_RUN` on an expiry tick with auto-reload set (*reload*).

Top module: `pwm_timer5`

## Requirements
- R1: The control word (address 0) gives channel 0 bits 3:0 and channel n≥1 bits 4(n+1)+3:4(n+1). Bits 7:4 always read 0. Within a nibble, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload.
- R2: For the last channel (bits 23:20), auto-reload is nibble bit 2 (bit 22). That nibble has no invert flag, its bit 3 (bit 23) always reads 0, and its output is never inverted. Bits 31:24 read 0.
- R3: Address 1+2n is the count buffer of channel n and address 2+2n is its compare buffer. Reads return the last written value, and unmapped addresses read 0. After reset, every register reads 0 and all outputs are low.
- R4: While a channel's manual-update flag is set, each tick copies both buffers into the active pair. During that time the output sits at its inactive level and no counting happens. The channel starts counting from the loaded count one cycle after the flag is cleared.
- R5: With auto-reload set, a period lasts count+1 ticks, and the active pair is reloaded from the buffers when the counter expires at 0.
- R6: Before inversion, the output is high while the counter is at or below the compare value, which gives compare+1 high ticks per period.
- R7: A compare value of all ones gives an output that is high for the whole period.
- R8: With auto-reload clear, the channel runs one period. After the tick at which the counter sits at 0, its output stays inactive until it is re-armed by manual update.
- R9: The invert flag flips the output polarity, including the idle level. A write changes the invert flag only while that channel's start flag is currently 0. Otherwise the old invert value is kept.
- R10: Clearing start freezes the counter and drives the output to its inactive level at once. Setting start again resumes counting from the frozen value.
- R11: The counter advances only in cycles where `tick` is high. With `tick` low, the output holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data for `addr`, combinational |
| tick | input | 1 | Timer tick enable |
| pwm_out | output | NUM_CH | Channel outputs, bit n for channel n |

## Verification
The bench targets the irregular control layout. A design that kept the hole, or gave the last channel an invert bit, would read back a control word other than 0x007FFF0F after an all-ones write. It would also fail to make channel 4 periodic when bit 22 is set. Waveforms are checked against the exact period and duty ratios: an off-by-one counter would show count or count+2 ticks per period, and a compare that excludes equality would lose one high tick. The bench also covers the full-duty compare, the single-shot expiry, freeze-and-resume from the frozen count, and a change of invert attempted while the channel runs. A design that let polarity change mid-run would show a flipped idle level after stop.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;

    typedef enum logic [1:0] {
        CH_STOP = 2'd0,
        CH_LOAD = 2'd1,
        CH_RUN  = 2'd2,
        CH_DONE = 2'd3
    } ch_state_e;

    // Lowest control-word bit of a channel's nibble: one nibble is skipped after channel 0.
    function automatic int nib_base(int ch);
        return 4 * ((ch == 0) ? 0 : ch + 1);
    endfunction

endpackage

// File: rtl/pwm5_regs.sv
module pwm5_regs #(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic [DATA_W-1:0]              ctrl_view,
    output logic [NUM_CH-1:0]              start_o,
    output logic [NUM_CH-1:0]              manual_o,
    output logic [NUM_CH-1:0]              inv_o,
    output logic [NUM_CH-1:0]              reload_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cnt_buf_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_buf_o
);

    localparam int CTRL_W = 4 * (NUM_CH + 1);

    logic ctrl_we;
    logic unused_wd;
    logic [NUM_CH:0][DATA_W-1:0] view_acc;
    logic [NUM_CH:0][DATA_W-1:0] rd_acc;

    assign ctrl_we   = wr_en && (addr == '0);
    assign unused_wd = ^wdata;
    assign view_acc[0] = '0;
    assign rd_acc[0]   = (addr == '0) ? ctrl_view : '0;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int LSB = pwm5_pkg::nib_base(ch);
        localparam bit LAST = (ch == NUM_CH - 1);
        localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(1 + 2 * ch);
        localparam logic [ADDR_W-1:0] CMP_A = ADDR_W'(2 + 2 * ch);

        logic [3:0] wn;
        logic [3:0] nib;
        logic st_q, mu_q, inv_q, rl_q;
        logic [CNT_W-1:0] cnt_q, cmp_q;

        assign wn = wdata[LSB +: 4];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= 1'b0;
                mu_q  <= 1'b0;
                inv_q <= 1'b0;
                rl_q  <= 1'b0;
            end else if (ctrl_we) begin
                st_q <= wn[0];
                mu_q <= wn[1];
                rl_q <= LAST ? wn[2] : wn[3];
                // polarity only moves while this channel is stopped
                if (!LAST && !st_q) begin
                    inv_q <= wn[2];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
                cmp_q <= '0;
            end else if (wr_en) begin
                if (addr == CNT_A) cnt_q <= wdata[CNT_W-1:0];
                if (addr == CMP_A) cmp_q <= wdata[CNT_W-1:0];
            end
        end

        assign nib = LAST ? {1'b0, rl_q, mu_q, st_q} : {rl_q, inv_q, mu_q, st_q};

        assign start_o[ch]   = st_q;
        assign manual_o[ch]  = mu_q;
        assign inv_o[ch]     = inv_q;
        assign reload_o[ch]  = rl_q;
        assign cnt_buf_o[ch] = cnt_q;
        assign cmp_buf_o[ch] = cmp_q;

        assign view_acc[ch+1] = view_acc[ch] | (DATA_W'(nib) << LSB);
        assign rd_acc[ch+1]   = rd_acc[ch]
                              | ((addr == CNT_A) ? DATA_W'(cnt_q) : '0)
                              | ((addr == CMP_A) ? DATA_W'(cmp_q) : '0);
    end

    if (CTRL_W > DATA_W) begin : g_bad_width
        initial $error("control word does not fit the data width");
    end

    assign ctrl_view = view_acc[NUM_CH];
    assign rdata     = rd_acc[NUM_CH];

endmodule

// File: rtl/pwm5_chan.sv
module pwm5_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             manual,
    input  logic             invert,
    input  logic             reload,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic             pwm_o
);

    import pwm5_pkg::*;

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cmp_q, cmp_d;
    logic             active;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_STOP;
            cnt_q   <= '0;
            cmp_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cmp_q   <= cmp_d;
        end
    end

    // next state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cmp_d   = cmp_q;
        if (manual) begin
            state_d = CH_LOAD;                       // arm
            if (tick) begin
                cnt_d = cnt_buf;
                cmp_d = cmp_buf;
            end
        end else begin
            unique case (state_q)
                CH_STOP: begin
                    if (start) state_d = CH_RUN;     // resume
                end
                CH_LOAD: begin
                    state_d = start ? CH_RUN : CH_STOP;  // launch / park
                end
                CH_RUN: begin
                    if (!start) begin
                        state_d = CH_STOP;           // halt
                    end else if (tick) begin
                        if (cnt_q == '0) begin
                            if (reload) begin        // reload
                                cnt_d = cnt_buf;
                                cmp_d = cmp_buf;
                            end else begin
                                state_d = CH_DONE;   // expire
                            end
                        end else begin
                            cnt_d = cnt_q - CNT_W'(1);
                        end
                    end
                end
                CH_DONE: begin
                    if (!start) state_d = CH_STOP;   // release
                end
            endcase
        end
    end

    // output
    always_comb begin
        active = (state_q == CH_RUN) && start && !manual
               && ((cmp_q == '1) || (cnt_q <= cmp_q));
        pwm_o  = active ^ invert;
    end

endmodule

// File: rtl/pwm_timer5.sv
module pwm_timer5 #(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [DATA_W-1:0]            ctrl_view;
    logic [NUM_CH-1:0]            start_v, manual_v, inv_v, reload_v;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf, cmp_buf;

    pwm5_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .ctrl_view (ctrl_view),
        .start_o   (start_v),
        .manual_o  (manual_v),
        .inv_o     (inv_v),
        .reload_o  (reload_v),
        .cnt_buf_o (cnt_buf),
        .cmp_buf_o (cmp_buf)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pwm5_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .start   (start_v[ch]),
            .manual  (manual_v[ch]),
            .invert  (inv_v[ch]),
            .reload  (reload_v[ch]),
            .cnt_buf (cnt_buf[ch]),
            .cmp_buf (cmp_buf[ch]),
            .pwm_o   (pwm_out[ch])
        );
    end

endmodule

// File: rtl/pwm_timer5_chk.sv
module pwm_timer5_chk #(
    parameter int NUM_CH = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] start_v,
    input logic [NUM_CH-1:0] manual_v,
    input logic [NUM_CH-1:0] inv_v,
    input logic [DATA_W-1:0] ctrl_view
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        // R10
        stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !start_v[ch] |-> (pwm_out[ch] == inv_v[ch]));
        // R4
        manual_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            manual_v[ch] |-> (pwm_out[ch] == inv_v[ch]));
        // R9
        inv_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            start_v[ch] |=> $stable(inv_v[ch]));
    end

    // R2
    last_noinv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_v[NUM_CH-1] && !ctrl_view[4*NUM_CH+3]);
    // R1
    gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_view[7:4] == 4'h0);

endmodule

bind pwm_timer5 pwm_timer5_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_out   (pwm_out),
    .start_v   (start_v),
    .manual_v  (manual_v),
    .inv_v     (inv_v),
    .ctrl_view (ctrl_view)
);

// File: tb/sim_pwm_timer5.sv
module sim_pwm_timer5;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 5;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              tick = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [NUM_CH-1:0] pwm_out;

    int n_chk = 0;
    int n_fail = 0;

    pwm_timer5 #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick(tick), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; tick = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(int a, logic [31:0] d);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        addr = ADDR_W'(a);
        #1;
        d = rdata;
    endtask

    function automatic logic exp_out(int c0, int cmp, int k, bit auto_rl);
        int c;
        if (auto_rl) c = c0 - (k % (c0 + 1));
        else if (k > c0) return 1'b0;
        else c = c0 - k;
        return (c <= cmp);
    endfunction

    function automatic logic [31:0] manual_bit(int ch);
        return 32'(1) << (((ch == 0) ? 0 : 4 * (ch + 1)) + 1);
    endfunction

    task automatic arm(int ch, int c0, int cmp, logic [31:0] run);
        wr(1 + 2 * ch, c0);
        wr(2 + 2 * ch, cmp);
        wr(0, run | manual_bit(ch));
        wr(0, run);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        check("R3", 32'(pwm_out), 0, "outputs after reset");
        for (int a = 0; a < 12; a++) begin
            rd(a, v);
            check("R3", v, 0, $sformatf("addr %0d after reset", a));
        end
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        do_reset();
        for (int ch = 0; ch < NUM_CH; ch++) begin
            wr(1 + 2 * ch, 32'h1000 + ch);
            wr(2 + 2 * ch, 32'h2000 + ch);
        end
        for (int ch = 0; ch < NUM_CH; ch++) begin
            rd(1 + 2 * ch, v); check("R3", v, 32'h1000 + ch, $sformatf("count buf ch%0d", ch));
            rd(2 + 2 * ch, v); check("R3", v, 32'h2000 + ch, $sformatf("compare buf ch%0d", ch));
        end
        // R1 R2: all-ones write exposes the hole, the missing bit 23 and the upper bits
        wr(0, 32'hFFFF_FFFF);
        rd(0, v);
        check("R1", v, 32'h007F_FF0F, "control layout after all-ones write");
        check("R2", 32'(pwm_out[4]), 0, "last channel never inverted");
    endtask

    task automatic t_periodic();
        do_reset();
        arm(0, 4, 1, 32'h9);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            check("R5", 32'(pwm_out[0]), 32'(exp_out(4, 1, k, 1'b1)), $sformatf("ch0 period k=%0d", k));
        end
        tick = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R11", 32'(pwm_out[0]), 32'(exp_out(4, 1, 6, 1'b1)), "hold without tick");
        end
        tick = 1'b1;
        for (int k = 7; k < 12; k++) begin
            @(negedge clk);
            check("R6", 32'(pwm_out[0]), 32'(exp_out(4, 1, k, 1'b1)), $sformatf("ch0 duty k=%0d", k));
        end
    endtask

    task automatic t_freeze();
        do_reset();
        arm(0, 4, 1, 32'h9);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10", 32'(pwm_out[0]), 32'(exp_out(4, 1, k, 1'b1)), "before stop");
        end
        wr(0, 32'h8);
        check("R10", 32'(pwm_out[0]), 0, "inactive right after stop");
        repeat (3) begin
            @(negedge clk);
            check("R10", 32'(pwm_out[0]), 0, "inactive while stopped");
        end
        wr(0, 32'h9);
        check("R10", 32'(pwm_out[0]), 0, "restart cycle");
        // frozen at count 1, then 0, then reload to 4
        @(negedge clk); check("R10", 32'(pwm_out[0]), 1, "resume at frozen count 1");
        @(negedge clk); check("R10", 32'(pwm_out[0]), 1, "resume count 0");
        @(negedge clk); check("R10", 32'(pwm_out[0]), 0, "resume reload to 4");
    endtask

    task automatic t_full_and_manual();
        logic [31:0] v;
        do_reset();
        arm(1, 3, 32'hFFFF, 32'h900);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R7", 32'(pwm_out[1]), 1, $sformatf("full duty k=%0d", k));
        end
        wr(0, 32'h900 | manual_bit(1));
        for (int k = 0; k < 4; k++) begin
            check("R4", 32'(pwm_out[1]), 0, "inactive while manual held");
            @(negedge clk);
        end
        rd(0, v);
        check("R4", v, 32'hB00, "manual flag readback");
        wr(0, 32'h900);
        check("R4", 32'(pwm_out[1]), 0, "still loading");
        @(negedge clk);
        check("R4", 32'(pwm_out[1]), 1, "running after manual cleared");
    endtask

    task automatic t_oneshot();
        do_reset();
        arm(2, 2, 0, 32'h1000);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            check("R8", 32'(pwm_out[2]), 32'(exp_out(2, 0, k, 1'b0)), $sformatf("one-shot k=%0d", k));
        end
    endtask

    task automatic t_invert();
        logic [31:0] v;
        do_reset();
        wr(0, 32'h4_0000);
        check("R9", 32'(pwm_out[3]), 1, "inverted idle level");
        arm(3, 2, 0, 32'hD_0000);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R9", 32'(pwm_out[3]), 32'(!exp_out(2, 0, k, 1'b1)), $sformatf("inverted wave k=%0d", k));
        end
        wr(0, 32'h9_0000);
        rd(0, v);
        check("R9", v, 32'hD_0000, "invert kept while running");
        wr(0, 32'h0);
        rd(0, v);
        check("R9", v, 32'h4_0000, "invert kept on stop write");
        check("R9", 32'(pwm_out[3]), 1, "idle still inverted");
        wr(0, 32'h0);
        check("R9", 32'(pwm_out[3]), 0, "invert cleared while stopped");
    endtask

    task automatic t_last();
        do_reset();
        arm(4, 2, 0, 32'h50_0000);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            check("R2", 32'(pwm_out[4]), 32'(exp_out(2, 0, k, 1'b1)), $sformatf("last ch reload k=%0d", k));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_regmap();
        t_periodic();
        t_freeze();
        t_full_and_manual();
        t_oneshot();
        t_invert();
        t_last();
        summary();
        $finish;
    end

endmodule